// File: doc/BRIEF.md
# General-Purpose Pin Controller with Output Source Selection

This block owns a set of up to sixteen general-purpose pins. For every pin it holds an output data bit, a two-bit drive mode and a five-bit output source selector. The selector chooses whether the pin carries its own data bit or one of a small set of internal signals. Pin inputs pass through a two-flop synchronizer. Software reads the synchronized values back through the same word that holds the output data bits.

Each pin also raises a level-sensitive interrupt. A per-pin polarity bit sets the active level. The interrupt feeds two paths. The clocked path has an enable, a sticky cause bit that software clears by writing 1, and a mask, and it drives `irq_sync`. The unclocked path has its own enable and mask and drives `irq_async` straight from the raw pad levels, so it still works when the clock is stopped.

A plain word-wide register bus gives access. Writes take effect at the clock edge where they are presented. A read returns its data one cycle after the request, with `bus_rvalid` high. The bus never stalls, so there is no back-pressure. The register map uses word addresses: 0 data, 1 drive mode, 2 to 4 source selectors, 5 polarity, 6 clocked enable, 7 clocked mask, 8 clocked cause, 9 unclocked enable, 10 unclocked mask.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0, `pad_oe` is all zero, `pad_out` is all zero, and both interrupt outputs are low.
- R2: The data word (address 0) holds the output data bits in bits [15:0], with pin n at bit n. Bits [31:16] return the synchronized input values, with pin n at bit 16+n. Writes to bits [31:16] have no effect.
- R3: A pad level change shows up in the data word readback for a read presented at the third rising edge after the change, and not for a read at the second.
- R4: The drive-mode word (address 1) holds a 2-bit field per pin at bit 2n. `pad_oe[n]` is high exactly when that field is non-zero.
- R5: The selector for pin n is the 5-bit field at bit (n mod 6)*5 of the word at address 2 + n/6. Value 0 drives `pad_out[n]` from data bit n. Value k in 1..NUM_SRC drives it from `sig_src[k-1]`. Any larger value drives 0. Bits outside the fields read back as 0.
- R6: Polarity bit n (address 5) sets the active level of pin n: 0 means active high and 1 means active low. This applies to both interrupt paths.
- R7: Cause bit n (address 8) sets when synchronized pin n is active and clocked enable bit n (address 6) is 1. It then holds until software writes 1 to that bit. If a clear and a set fall in the same cycle, the set wins.
- R8: `irq_sync` is high exactly when some cause bit is set and its clocked mask bit (address 7) is 1.
- R9: `irq_async` follows the raw pads with no clock edge in its path. It is high exactly when some pin is at its active level with both its unclocked enable bit (address 9) and its unclocked mask bit (address 10) set.
- R10: `bus_rvalid` is high in the cycle after each read request and only then. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | NUM_PINS | Raw pin input levels |
| sig_src | input | NUM_SRC | Internal signals selectable as pin outputs |
| pad_out | output | NUM_PINS | Pin output levels |
| pad_oe | output | NUM_PINS | Pin output enables |
| irq_sync | output | 1 | Clocked interrupt request |
| irq_async | output | 1 | Unclocked interrupt request |

## Verification
Two events can hit the same cause bit in one cycle: the hardware setting it and a software write-one clearing it. The bench provokes this by holding a pin at its active level with the clocked enable set, then writing 1 to that cause bit. The following read must show the bit still set, because setting has priority. The bench then drops the pin to its inactive level, waits for the synchronizer to drain, and repeats the clear. This time the bit must read 0 and `irq_sync` must fall.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 32;
  localparam int SEL_W        = 5;
  localparam int MODE_W       = 2;
  localparam int PINS_PER_MUX = 6;
  localparam int IN_LSB       = 16;
  localparam int SYNC_STAGES  = 2;

  localparam logic [ADDR_W-1:0] A_DATA   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DRIVE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MUX0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_POL    = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEN    = 4'd6;
  localparam logic [ADDR_W-1:0] A_SMASK  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SCAUSE = 4'd8;
  localparam logic [ADDR_W-1:0] A_AEN    = 4'd9;
  localparam logic [ADDR_W-1:0] A_AMASK  = 4'd10;

  // word address holding the selector of a pin
  function automatic logic [ADDR_W-1:0] sel_addr(input int pin);
    return ADDR_W'(int'(A_MUX0) + pin / PINS_PER_MUX);
  endfunction

  // bit offset of a pin's selector inside its word
  function automatic int sel_lsb(input int pin);
    return (pin % PINS_PER_MUX) * SEL_W;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= raw_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_ctrl_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  input  logic [N-1:0]         in_sync,
  input  logic [N-1:0]         cause_q,
  output logic [N-1:0]         out_q,
  output logic [MODE_W*N-1:0]  mode_q,
  output logic [SEL_W*N-1:0]   sel_flat,
  output logic [N-1:0]         pol_q,
  output logic [N-1:0]         sen_q,
  output logic [N-1:0]         smask_q,
  output logic [N-1:0]         aen_q,
  output logic [N-1:0]         amask_q,
  output logic [N-1:0]         cause_clr
);
  logic [SEL_W-1:0]  sel_q [N];
  logic [DATA_W-1:0] rd_word;
  logic              wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      sen_q   <= '0;
      smask_q <= '0;
      aen_q   <= '0;
      amask_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_DATA:  out_q   <= bus_wdata[N-1:0];
        A_DRIVE: mode_q  <= bus_wdata[MODE_W*N-1:0];
        A_POL:   pol_q   <= bus_wdata[N-1:0];
        A_SEN:   sen_q   <= bus_wdata[N-1:0];
        A_SMASK: smask_q <= bus_wdata[N-1:0];
        A_AEN:   aen_q   <= bus_wdata[N-1:0];
        A_AMASK: amask_q <= bus_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) sel_q[p] <= '0;
    end else begin
      for (int p = 0; p < N; p++)
        if (wr_en && bus_addr == sel_addr(p))
          sel_q[p] <= bus_wdata[sel_lsb(p) +: SEL_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flat
      assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
    end
  endgenerate

  assign cause_clr = (wr_en && bus_addr == A_SCAUSE) ? bus_wdata[N-1:0] : '0;

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      A_DATA: begin
        rd_word[N-1:0]       = out_q;
        rd_word[IN_LSB +: N] = in_sync;
      end
      A_DRIVE:  rd_word[MODE_W*N-1:0] = mode_q;
      A_POL:    rd_word[N-1:0] = pol_q;
      A_SEN:    rd_word[N-1:0] = sen_q;
      A_SMASK:  rd_word[N-1:0] = smask_q;
      A_SCAUSE: rd_word[N-1:0] = cause_q;
      A_AEN:    rd_word[N-1:0] = aen_q;
      A_AMASK:  rd_word[N-1:0] = amask_q;
      default: begin
        for (int p = 0; p < N; p++)
          if (bus_addr == sel_addr(p))
            rd_word[sel_lsb(p) +: SEL_W] = sel_q[p];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= rd_en ? rd_word : '0;
      bus_rvalid <= rd_en;
    end
  end
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux
  import gpio_ctrl_pkg::*;
#(
  parameter int N       = 16,
  parameter int NUM_SRC = 4
) (
  input  logic [N-1:0]        out_q,
  input  logic [MODE_W*N-1:0] mode_q,
  input  logic [SEL_W*N-1:0]  sel_flat,
  input  logic [NUM_SRC-1:0]  sig_src,
  output logic [N-1:0]        pad_out,
  output logic [N-1:0]        pad_oe
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic [SEL_W-1:0] sel;
      logic             lvl;
      assign sel = sel_flat[g*SEL_W +: SEL_W];

      always_comb begin
        lvl = 1'b0;
        if (sel == '0) lvl = out_q[g];
        for (int k = 0; k < NUM_SRC; k++)
          if (sel == SEL_W'(k + 1)) lvl = sig_src[k];
      end

      assign pad_out[g] = lvl;
      assign pad_oe[g]  = |mode_q[g*MODE_W +: MODE_W];
    end
  endgenerate
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_raw,
  input  logic [N-1:0] in_sync,
  input  logic [N-1:0] pol_q,
  input  logic [N-1:0] sen_q,
  input  logic [N-1:0] smask_q,
  input  logic [N-1:0] aen_q,
  input  logic [N-1:0] amask_q,
  input  logic [N-1:0] cause_clr,
  output logic [N-1:0] cause_q,
  output logic         irq_sync,
  output logic         irq_async
);
  logic [N-1:0] act_sync, act_raw, set_vec;

  assign act_sync = in_sync ^ pol_q;
  assign act_raw  = pad_raw ^ pol_q;
  assign set_vec  = act_sync & sen_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~cause_clr) | set_vec;
  end

  assign irq_sync  = |(cause_q & smask_q);
  assign irq_async = |(act_raw & aen_q & amask_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_SRC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_SRC-1:0]  sig_src,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_sync,
  output logic                irq_async
);
  logic [NUM_PINS-1:0]        in_sync, cause_q, cause_clr;
  logic [NUM_PINS-1:0]        out_q, pol_q, sen_q, smask_q, aen_q, amask_q;
  logic [MODE_W*NUM_PINS-1:0] mode_q;
  logic [SEL_W*NUM_PINS-1:0]  sel_flat;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(in_sync)
  );

  gpio_regfile #(.N(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .in_sync(in_sync), .cause_q(cause_q),
    .out_q(out_q), .mode_q(mode_q), .sel_flat(sel_flat),
    .pol_q(pol_q), .sen_q(sen_q), .smask_q(smask_q),
    .aen_q(aen_q), .amask_q(amask_q), .cause_clr(cause_clr)
  );

  gpio_out_mux #(.N(NUM_PINS), .NUM_SRC(NUM_SRC)) u_mux (
    .out_q(out_q), .mode_q(mode_q), .sel_flat(sel_flat),
    .sig_src(sig_src), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_irq #(.N(NUM_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pad_raw(pad_in), .in_sync(in_sync),
    .pol_q(pol_q), .sen_q(sen_q), .smask_q(smask_q),
    .aen_q(aen_q), .amask_q(amask_q), .cause_clr(cause_clr),
    .cause_q(cause_q), .irq_sync(irq_sync), .irq_async(irq_async)
  );
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [3:0]   bus_addr,
  input logic         bus_rvalid,
  input logic [N-1:0] in_sync,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] sen_q,
  input logic [N-1:0] smask_q,
  input logic [N-1:0] aen_q,
  input logic [N-1:0] amask_q,
  input logic [N-1:0] cause_q,
  input logic [N-1:0] pad_oe,
  input logic         irq_sync,
  input logic         irq_async
);
  logic         clr_wr;
  logic [N-1:0] want_set;
  assign clr_wr   = bus_sel && bus_wr && bus_addr == A_SCAUSE;
  assign want_set = (in_sync ^ pol_q) & sen_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pad_oe == '0 && !irq_sync && !irq_async && cause_q == '0)
        else $error("outputs active during reset");
    end
  end

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_cause_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (want_set != '0) |=> ((cause_q & $past(want_set)) == $past(want_set)));

  assert_sync_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smask_q == '0) |-> !irq_sync);

  assert_async_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((aen_q & amask_q) == '0) |-> !irq_async);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .in_sync(in_sync),
  .pol_q(pol_q), .sen_q(sen_q), .smask_q(smask_q), .aen_q(aen_q),
  .amask_q(amask_q), .cause_q(cause_q), .pad_oe(pad_oe),
  .irq_sync(irq_sync), .irq_async(irq_async)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  localparam int N = 16;
  localparam int NSRC = 4;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0]    pad_in, pad_out, pad_oe;
  logic [NSRC-1:0] sig_src;
  logic        irq_sync, irq_async;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [N-1:0]   sh_out, sh_pol, sh_sen, sh_smask, sh_aen, sh_amask;
  logic [2*N-1:0] sh_mode;
  logic [4:0]     sh_sel [N];

  gpio_ctrl #(.NUM_PINS(N), .NUM_SRC(NSRC)) i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .sig_src(sig_src),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_sync(irq_sync), .irq_async(irq_async)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, input string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    check(req, {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mux_word(input int r);
    logic [31:0] w = '0;
    for (int p = 6*r; p < 6*r + 6 && p < N; p++) w[(p % 6)*5 +: 5] = sh_sel[p];
    return w;
  endfunction

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] v;
    for (int p = 0; p < N; p++) begin
      if (sh_sel[p] == 0) v[p] = sh_out[p];
      else if (sh_sel[p] <= NSRC) v[p] = sig_src[sh_sel[p] - 1];
      else v[p] = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] v;
    for (int p = 0; p < N; p++) v[p] = sh_mode[2*p +: 2] != 2'b00;
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, w;
    logic [N-1:0] exp_c;
    void'($urandom(32'h5EED_0042));
    rst_n = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = 0; sig_src = 0;
    sh_out = 0; sh_pol = 0; sh_sen = 0; sh_smask = 0; sh_aen = 0; sh_amask = 0; sh_mode = 0;
    for (int p = 0; p < N; p++) sh_sel[p] = 0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    check("R1 oe in reset", {16'd0, pad_oe}, 32'd0);
    check("R1 irq in reset", {30'd0, irq_sync, irq_async}, 32'd0);
    @(negedge clk) rst_n = 1;

    // R1 / R10: all registers zero, unmapped reads zero
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), rd, "R10 rvalid");
      check($sformatf("R1 reset value addr %0d", a), rd, 32'd0);
    end
    check("R1 pad_out after reset", {16'd0, pad_out}, 32'd0);

    // R3: synchronizer latency
    pad_in = 16'hA5C3;
    bus_read(4'd0, rd, "R10 rvalid");
    bus_read(4'd0, rd, "R10 rvalid");
    check("R3 second-edge read still old", rd, 32'd0);
    bus_read(4'd0, rd, "R10 rvalid");
    check("R3 third-edge read new", rd, {16'hA5C3, 16'h0000});

    // R2: input field not writable
    bus_write(4'd0, 32'hFFFF_1234); sh_out = 16'h1234;
    bus_read(4'd0, rd, "R10 rvalid");
    check("R2 data readback ignores upper write", rd, {16'hA5C3, 16'h1234});
    for (int i = 0; i < 8; i++) begin
      w = $urandom;
      pad_in = N'($urandom);
      bus_write(4'd0, w); sh_out = w[N-1:0];
      idle(3);
      bus_read(4'd0, rd, "R10 rvalid");
      check("R2 random data word", rd, {pad_in, sh_out});
    end

    // R4 / R5: random drive modes and selectors
    for (int i = 0; i < 30; i++) begin
      sh_mode = $urandom;
      sh_out  = N'($urandom);
      for (int p = 0; p < N; p++) sh_sel[p] = 5'($urandom_range(0, 7));
      if (i == 0) for (int p = 0; p < N; p++) sh_sel[p] = 5'd31;
      sig_src = NSRC'($urandom);
      bus_write(4'd1, sh_mode);
      bus_write(4'd0, {16'd0, sh_out});
      for (int r = 0; r < 3; r++) bus_write(4'(2 + r), mux_word(r) | 32'hC000_0000);
      #1;
      check("R4 pad_oe", {16'd0, pad_oe}, {16'd0, exp_oe()});
      check("R5 pad_out", {16'd0, pad_out}, {16'd0, exp_out()});
      if (i < 3) begin
        for (int r = 0; r < 3; r++) begin
          @(negedge clk);
          bus_read(4'(2 + r), rd, "R10 rvalid");
          check("R5 selector packing", rd, mux_word(r));
        end
        bus_read(4'd1, rd, "R10 rvalid");
        check("R4 mode readback", rd, sh_mode);
      end
      @(negedge clk);
    end

    // R6 / R9: unclocked path with random polarity
    for (int i = 0; i < 30; i++) begin
      sh_pol = N'($urandom); sh_aen = N'($urandom); sh_amask = N'($urandom);
      if (i < 4) sh_amask = 0;
      bus_write(4'd5, {16'd0, sh_pol});
      bus_write(4'd9, {16'd0, sh_aen});
      bus_write(4'd10, {16'd0, sh_amask});
      pad_in = N'($urandom);
      #1;
      check("R9 R6 irq_async", {31'd0, irq_async},
            {31'd0, |((pad_in ^ sh_pol) & sh_aen & sh_amask)});
      @(negedge clk);
    end
    sh_aen = 0; sh_amask = 0;
    bus_write(4'd9, 0); bus_write(4'd10, 0);

    // R7 / R8 directed: set, sticky, same-cycle clear
    sh_pol = 0; bus_write(4'd5, 0);
    pad_in = 0; idle(4);
    bus_write(4'd8, 32'hFFFF);
    pad_in = 16'h0005;
    bus_write(4'd6, 32'h0003); bus_write(4'd7, 32'h0);
    idle(4);
    bus_read(4'd8, rd, "R10 rvalid");
    check("R7 cause set only where enabled", rd, 32'h0001);
    check("R8 masked cause no irq", {31'd0, irq_sync}, 32'd0);
    bus_write(4'd7, 32'h0001);
    check("R8 unmasked cause raises irq", {31'd0, irq_sync}, 32'd1);
    pad_in = 0; idle(4);
    bus_read(4'd8, rd, "R10 rvalid");
    check("R7 cause sticky", rd, 32'h0001);
    pad_in = 16'h0001; idle(4);
    bus_write(4'd8, 32'h0001);
    bus_read(4'd8, rd, "R10 rvalid");
    check("R7 set wins over clear", rd, 32'h0001);
    pad_in = 0; idle(4);
    bus_write(4'd8, 32'h0001);
    bus_read(4'd8, rd, "R10 rvalid");
    check("R7 clear when inactive", rd, 32'h0000);
    check("R8 irq drops after clear", {31'd0, irq_sync}, 32'd0);
    bus_write(4'd5, 32'h0002);
    idle(4);
    bus_read(4'd8, rd, "R10 rvalid");
    check("R6 active-low sets cause", rd, 32'h0002);

    // R7 / R8 random rounds
    for (int i = 0; i < 10; i++) begin
      bus_write(4'd6, 0);
      bus_write(4'd8, 32'hFFFF);
      sh_pol = N'($urandom); sh_sen = N'($urandom); sh_smask = N'($urandom);
      pad_in = N'($urandom);
      bus_write(4'd5, {16'd0, sh_pol});
      bus_write(4'd7, {16'd0, sh_smask});
      bus_write(4'd6, {16'd0, sh_sen});
      idle(4);
      exp_c = (pad_in ^ sh_pol) & sh_sen;
      bus_read(4'd8, rd, "R10 rvalid");
      check("R7 random cause", rd, {16'd0, exp_c});
      check("R8 random irq_sync", {31'd0, irq_sync}, {31'd0, |(exp_c & sh_smask)});
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule